// File: doc/BRIEF.md
# Critical-thread switch usage monitor

This block sits beside a 4x4 router crossbar and records which input-to-output paths the latency-sensitive traffic uses. Each cycle the router may report one switch traversal: the input port, the output port, whether the flit is the head of its packet, and whether the packet belongs to one of the four threads currently predicted to be most critical. For every input/output pair the monitor keeps a small saturating counter. It advances only on head flits of critical packets, so each critical packet counts once.

A cycle timer divides time into intervals of a programmable length. When an interval closes, the counters stop. A selection phase then visits the outputs in ascending order, one per cycle. For each output it chooses the input with the largest nonzero count among the inputs not yet given to a lower-numbered output. The result is loaded into a port state table, and the bypass crossbar uses that table as its preset input-to-output configuration. On the same cycle all counters return to zero, so each table reflects one interval only.

The control is a three-state machine. RUN counts events and advances the timer. It takes the transition *interval end* to PICK once the timer reaches length-1 (a length of 0 behaves as 1). PICK stays for one cycle per output and takes *selection done* to LOAD after the last output. LOAD writes the table, clears the counters and the timer, and takes *reload* back to RUN. One full period therefore lasts interval_len + N_PORTS + 1 cycles.

Top module: `crit_usage_monitor`

## Requirements
- R1: While reset is asserted and until the first table load, every valid bit of the table is 0 and every selection field is 0.
- R2: A traversal is counted only when ev_valid, ev_head and ev_crit are all 1. A body flit (ev_head=0) or a non-critical packet (ev_crit=0) changes nothing in the next table.
- R3: There is a separate counter for each (input, output) pair. Output k's entry names the input whose count toward output k is largest. Selection field k occupies bits [2k+1:2k] of tbl_sel and holds an input index 0..3.
- R4: Equal counts are resolved in favour of the lower input index.
- R5: Outputs are assigned in ascending order. An input already given to a lower-numbered output is skipped, so no input appears in two valid entries.
- R6: Counters saturate at 2^CNT_W-1 (15 by default) instead of wrapping.
- R7: The table changes only on the LOAD cycle. Loads occur interval_len + N_PORTS + 1 cycles apart, the first one that many cycles after reset is released.
- R8: All counters are zero after each load, so a table depends only on the interval just ended.
- R9: Traversals reported during the PICK and LOAD cycles are not counted.
- R10: An output with no nonzero count from any eligible input has valid bit 0 and selection field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A switch traversal is reported this cycle |
| ev_in | input | 2 | Input port of the traversal |
| ev_out | input | 2 | Output port of the traversal |
| ev_head | input | 1 | Traversing flit is a packet head |
| ev_crit | input | 1 | Packet belongs to a top-four critical thread |
| interval_len | input | 16 | Counting window length in cycles (0 treated as 1) |
| tbl_valid | output | 4 | Per-output entry valid |
| tbl_sel | output | 8 | Per-output selected input, 2 bits per output |

## Verification
A wrong count, a lost clear or a bad mask inside the block stays hidden until the next load. It then shows at the ports as a wrong or missing table entry, a duplicated input, or an entry carried over from an older interval. That appears exactly one period after the fault, or one period later still for a clear that was missed. Each interval's stimulus is chosen so that wrapping, a wrong tie order, a missing skip, or counting filtered or out-of-window events gives a different table. A load at the wrong moment shows as a table that changes early or late relative to the fixed period.

// File: rtl/crit_usage_monitor_pkg.sv
package crit_usage_monitor_pkg;
    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_PICK = 2'd1,
        S_LOAD = 2'd2
    } mon_state_e;
endpackage

// File: rtl/pair_counter_array.sv
module pair_counter_array #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               inc_en,
    input  logic [IDX_W-1:0]                   inc_in,
    input  logic [IDX_W-1:0]                   inc_out,
    input  logic                               clr,
    output logic [N_PORTS*N_PORTS*CNT_W-1:0]   cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // counter for (output o, input i) lives at slot o*N_PORTS+i
    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        for (genvar i = 0; i < N_PORTS; i++) begin : g_in
            logic [CNT_W-1:0] cnt_q;
            logic             hit;
            assign hit = inc_en && (inc_in == IDX_W'(i)) && (inc_out == IDX_W'(o));
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt_q <= '0;
                end else if (hit && cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign cnt_flat[(o*N_PORTS+i)*CNT_W +: CNT_W] = cnt_q;
        end
    end
endmodule

// File: rtl/port_picker.sv
module port_picker #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic [N_PORTS*N_PORTS*CNT_W-1:0] cnt_flat,
    input  logic [IDX_W-1:0]                 out_idx,
    input  logic [N_PORTS-1:0]               taken,
    output logic                             found,
    output logic [IDX_W-1:0]                 best
);
    logic [CNT_W-1:0] best_cnt;
    logic [CNT_W-1:0] cur;

    // ascending scan with strict compare: ties keep the lower index
    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_cnt = '0;
        cur      = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            cur = cnt_flat[(int'(out_idx)*N_PORTS + i)*CNT_W +: CNT_W];
            if (!taken[i] && cur != '0 && (!found || cur > best_cnt)) begin
                found    = 1'b1;
                best     = IDX_W'(i);
                best_cnt = cur;
            end
        end
    end
endmodule

// File: rtl/crit_usage_monitor.sv
module crit_usage_monitor
    import crit_usage_monitor_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    parameter int LEN_W   = 16,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_valid,
    input  logic [IDX_W-1:0]           ev_in,
    input  logic [IDX_W-1:0]           ev_out,
    input  logic                       ev_head,
    input  logic                       ev_crit,
    input  logic [LEN_W-1:0]           interval_len,
    output logic [N_PORTS-1:0]         tbl_valid,
    output logic [N_PORTS*IDX_W-1:0]   tbl_sel
);
    localparam logic [IDX_W-1:0] LAST_OUT = IDX_W'(N_PORTS - 1);

    mon_state_e                         state_q, state_d;
    logic [LEN_W-1:0]                   timer_q;
    logic [LEN_W-1:0]                   len_m1;
    logic                               last_run;
    logic [IDX_W-1:0]                   pick_q;
    logic [N_PORTS-1:0]                 taken_q;
    logic [N_PORTS-1:0]                 shadow_v;
    logic [IDX_W-1:0]                   shadow_sel [N_PORTS];
    logic [IDX_W-1:0]                   tbl_sel_q  [N_PORTS];
    logic [N_PORTS*N_PORTS*CNT_W-1:0]   cnt_flat;
    logic                               inc_en;
    logic                               load_ph;
    logic                               found;
    logic [IDX_W-1:0]                   best;

    assign len_m1   = (interval_len == '0) ? '0 : interval_len - 1'b1;
    assign last_run = (timer_q >= len_m1);
    assign load_ph  = (state_q == S_LOAD);
    assign inc_en   = ev_valid && ev_head && ev_crit && (state_q == S_RUN);

    pair_counter_array #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (inc_en),
        .inc_in   (ev_in),
        .inc_out  (ev_out),
        .clr      (load_ph),
        .cnt_flat (cnt_flat)
    );

    port_picker #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_pick (
        .cnt_flat (cnt_flat),
        .out_idx  (pick_q),
        .taken    (taken_q),
        .found    (found),
        .best     (best)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // transitions: interval end, selection done, reload
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:   if (last_run)           state_d = S_PICK;
            S_PICK:  if (pick_q == LAST_OUT) state_d = S_LOAD;
            S_LOAD:                          state_d = S_RUN;
            default:                         state_d = S_RUN;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q   <= '0;
            pick_q    <= '0;
            taken_q   <= '0;
            shadow_v  <= '0;
            tbl_valid <= '0;
            for (int k = 0; k < N_PORTS; k++) begin
                shadow_sel[k] <= '0;
                tbl_sel_q[k]  <= '0;
            end
        end else begin
            unique case (state_q)
                S_RUN: begin
                    timer_q <= timer_q + 1'b1;
                    if (last_run) begin
                        pick_q   <= '0;
                        taken_q  <= '0;
                        shadow_v <= '0;
                        for (int k = 0; k < N_PORTS; k++) shadow_sel[k] <= '0;
                    end
                end
                S_PICK: begin
                    if (found) begin
                        shadow_v[pick_q]   <= 1'b1;
                        shadow_sel[pick_q] <= best;
                        taken_q[best]      <= 1'b1;
                    end
                    pick_q <= pick_q + 1'b1;
                end
                S_LOAD: begin
                    timer_q   <= '0;
                    tbl_valid <= shadow_v;
                    for (int k = 0; k < N_PORTS; k++) tbl_sel_q[k] <= shadow_sel[k];
                end
                default: timer_q <= '0;
            endcase
        end
    end

    for (genvar k = 0; k < N_PORTS; k++) begin : g_flat
        assign tbl_sel[k*IDX_W +: IDX_W] = tbl_sel_q[k];
    end
endmodule

// File: rtl/crit_usage_monitor_chk.sv
module crit_usage_monitor_chk #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             load_ph,
    input logic [N_PORTS*N_PORTS*CNT_W-1:0] cnt_flat,
    input logic [N_PORTS-1:0]               tbl_valid,
    input logic [N_PORTS*IDX_W-1:0]         tbl_sel
);
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < N_PORTS; a++)
            for (int b = a + 1; b < N_PORTS; b++)
                if (tbl_valid[a] && tbl_valid[b] &&
                    tbl_sel[a*IDX_W +: IDX_W] == tbl_sel[b*IDX_W +: IDX_W])
                    dup = 1'b1;
    end

    // R5
    unique_in_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    // R7
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ph |=> ($stable(tbl_valid) && $stable(tbl_sel)));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ph |=> (cnt_flat == '0));

    for (genvar c = 0; c < N_PORTS*N_PORTS; c++) begin : g_cnt
        // R6
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load_ph |=> (cnt_flat[c*CNT_W +: CNT_W] >= $past(cnt_flat[c*CNT_W +: CNT_W])));
    end

    for (genvar k = 0; k < N_PORTS; k++) begin : g_out
        // R10
        idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tbl_valid[k] |-> (tbl_sel[k*IDX_W +: IDX_W] == '0));
    end
endmodule

bind crit_usage_monitor crit_usage_monitor_chk #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ph   (load_ph),
    .cnt_flat  (cnt_flat),
    .tbl_valid (tbl_valid),
    .tbl_sel   (tbl_sel)
);

// File: tb/sim_crit_usage_monitor.sv
module sim_crit_usage_monitor;
    localparam int L  = 40;
    localparam int NP = 4;
    localparam int P  = L + NP + 1;
    localparam int NV = 6;

    function automatic logic [11:0] bst(int i, int o, int n, int h, int c);
        return {2'(i), 2'(o), 6'(n), 1'(h), 1'(c)};
    endfunction

    // bursts listed b3,b2,b1,b0; each burst {in,out,count,head,crit}
    localparam logic [47:0] BURSTS [NV] = '{
        {12'h0,           bst(2,1,1,1,1), bst(1,0,2,1,1), bst(0,0,3,1,1)},
        {12'h0,           bst(1,1,2,1,1), bst(2,3,5,0,1), bst(3,2,5,1,0)},
        {bst(0,3,1,1,1),  bst(3,1,2,1,1), bst(2,1,5,1,1), bst(2,0,4,1,1)},
        {bst(2,3,2,1,1),  bst(0,2,3,1,1), bst(1,2,3,1,1), bst(3,2,3,1,1)},
        {12'h0,           12'h0,          bst(3,0,20,1,1), bst(1,0,16,1,1)},
        {12'h0,           12'h0,          12'h0,           12'h0}
    };
    // expected {valid[3:0], sel[7:0]}
    localparam logic [11:0] EXPECT [NV] = '{12'h308, 12'h204, 12'hB0E, 12'hC80, 12'h101, 12'h000};
    localparam string VTAG [NV] = '{"R3", "R2", "R5", "R4", "R6", "R8"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0, ev_head = 1'b0, ev_crit = 1'b0;
    logic [1:0]  ev_in = '0, ev_out = '0;
    logic [15:0] interval_len = 16'(L);
    logic [3:0]  tbl_valid;
    logic [7:0]  tbl_sel;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    crit_usage_monitor u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_in(ev_in), .ev_out(ev_out),
        .ev_head(ev_head), .ev_crit(ev_crit), .interval_len(interval_len),
        .tbl_valid(tbl_valid), .tbl_sel(tbl_sel)
    );

    task automatic check_tbl(input logic [11:0] exp, input string tag);
        checks++;
        if ({tbl_valid, tbl_sel} !== exp) begin
            fails++;
            $display("FAIL %s: table=%h expected=%h", tag, {tbl_valid, tbl_sel}, exp);
        end
    endtask

    task automatic drive_from(input logic [47:0] bl, input int c);
        int acc = 0;
        ev_valid = 1'b0;
        for (int b = 0; b < 4; b++) begin
            logic [11:0] w = bl[b*12 +: 12];
            if (c >= acc && c < acc + int'(w[7:2])) begin
                ev_valid = 1'b1;
                ev_in    = w[11:10];
                ev_out   = w[9:8];
                ev_head  = w[1];
                ev_crit  = w[0];
            end
            acc += int'(w[7:2]);
        end
    endtask

    // one full period starting at a negedge just before the interval's first edge
    task automatic run_interval(input logic [47:0] bl, input bit late,
                                input logic [11:0] prev, input logic [11:0] exp, input string tag);
        for (int c = 0; c < P; c++) begin
            if (late) begin
                ev_valid = (c >= L);
                ev_in = 2'd2; ev_out = 2'd2; ev_head = 1'b1; ev_crit = 1'b1;
            end else begin
                drive_from(bl, c);
            end
            if (c == P - 1) check_tbl(prev, "R7 hold before load");
            @(negedge clk);
        end
        ev_valid = 1'b0;
        check_tbl(exp, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] prev;
        repeat (3) @(negedge clk);
        check_tbl(12'h000, "R1 during reset");
        rst_n = 1'b1;
        prev = 12'h000;
        // table-driven intervals
        for (int v = 0; v < NV; v++) begin
            run_interval(BURSTS[v], 1'b0, prev, EXPECT[v], VTAG[v]);
            prev = EXPECT[v];
        end
        // R9: traffic only in the PICK/LOAD cycles is not counted
        run_interval(48'h0, 1'b1, prev, 12'h000, "R9 late events");
        run_interval(48'h0, 1'b0, 12'h000, 12'h000, "R9 no carry-over");
        // R10: all-body-flit interval leaves every entry invalid, after a busy one
        run_interval(BURSTS[0], 1'b0, 12'h000, EXPECT[0], "R3 repeat");
        run_interval({36'h0, bst(0,0,9,0,1)}, 1'b0, EXPECT[0], 12'h000, "R10 empty entries");
        // R1: reset clears a loaded table
        run_interval(BURSTS[2], 1'b0, 12'h000, EXPECT[2], "R5 repeat");
        rst_n = 1'b0;
        @(negedge clk);
        check_tbl(12'h000, "R1 reset after load");
        finish_run();
    end
endmodule